// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block turns single-word read and write requests from an on-chip bus into the control waveforms of an asynchronous static RAM. The RAM holds 65,536 words of 16 bits. Its controls are active-low: chip enable, write enable, output enable, and one enable for each byte lane. All timing is counted in system clock cycles. Parameters set the address setup before the write strobe, the width of the strobe, the data hold after the strobe rises, the read access wait, and the idle turnaround that follows every read.

The request side is a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so back-pressure lasts for one whole access. While `req_ready` is low, the requester may hold or change its fields and none of them is sampled. Read data comes back as a one-cycle `rsp_valid` pulse. That channel has no back-pressure: the consumer must take the word in that cycle. The shared data bus is split into output, output-enable and input signals. The pad logic outside the block combines them.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, chip enable, write enable, output enable and both byte enables are high (inactive), `mem_dq_oe` is 0 and `req_ready` is 1.
- R2: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the access and any turnaround have finished.
- R3: A write holds chip enable low for SETUP_CYC + WE_CYC + HOLD_CYC cycles. Write enable is high for the first SETUP_CYC cycles, low for the next WE_CYC cycles and high again for the last HOLD_CYC cycles. Output enable stays high throughout.
- R4: Through every cycle of a write, `mem_dq_oe` is 1 and `mem_dq_out` equals the accepted write word. The word is therefore stable across the rising edge of write enable, where the RAM captures it.
- R5: A read holds chip enable and output enable low and write enable high for RD_CYC cycles, with `mem_dq_oe` at 0.
- R6: Read data is sampled from `mem_dq_in` in the last read cycle. `rsp_valid` is 1 for exactly the one cycle that follows, with `rsp_rdata` holding the sample.
- R7: `req_be[0]`=1 selects bits 7:0 and `req_be[1]`=1 selects bits 15:8. During an access, the lower-byte enable is low only if `req_be[0]` was 1 and the upper-byte enable is low only if `req_be[1]` was 1. In `rsp_rdata`, a lane that was not selected reads as 0. A write with mask 00 leaves the RAM unchanged.
- R8: After each read come TURN_CYC (at least 1) cycles with chip enable high, output enable high, `mem_dq_oe` 0 and `req_ready` 0. Only after these can a following request start.
- R9: `mem_dq_oe` is never 1 while output enable is low.
- R10: `mem_addr` stays at the accepted address throughout an access. Request fields that change while `req_ready` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | 16 | Read word, unselected lanes zero |
| mem_addr | output | 16 | RAM address bus |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_lb_n | output | 1 | RAM lower byte enable, active low |
| mem_ub_n | output | 1 | RAM upper byte enable, active low |
| mem_dq_out | output | 16 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable for driving mem_dq_out |
| mem_dq_in | input | 16 | Data arriving from the RAM |

## Verification
Two things can coincide. The read-data pulse falls in the first turnaround cycle. A write request may already be waiting with `req_valid` high at that moment. The bench holds a write request valid from the cycle a read completes, with a new address and data presented while `req_ready` is low. The reference model then requires, on every clock, that the single `rsp_valid` pulse carries the old read word. It also requires that the controller does not drive the bus and that no chip-enable cycle begins before the turnaround ends. Only after that does it expect the write to start at the address and data last presented.

// File: rtl/asram_pkg.sv
package asram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RACC   = 3'd4,
    ST_TURN   = 3'd5
  } asram_state_e;

  function automatic int max5(int a, int b, int c, int d, int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction
endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  AST_TMR_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done); // R3
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 2,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 2,
  parameter int TURN_CYC  = 1,
  parameter int TW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          acc_write,
  input  logic          tmr_done,
  output asram_state_e  state,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val
);
  asram_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        if (acc_write) begin
          state_d = ST_WSETUP;
          tmr_val = TW'(SETUP_CYC - 1);
        end else begin
          state_d = ST_RACC;
          tmr_val = TW'(RD_CYC - 1);
        end
      end
      ST_WSETUP: if (tmr_done) begin
        state_d  = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = TW'(WE_CYC - 1);
      end
      ST_WPULSE: if (tmr_done) begin
        state_d  = ST_WHOLD;
        tmr_load = 1'b1;
        tmr_val  = TW'(HOLD_CYC - 1);
      end
      ST_WHOLD: if (tmr_done) state_d = ST_IDLE;
      ST_RACC: if (tmr_done) begin
        state_d  = ST_TURN;
        tmr_load = 1'b1;
        tmr_val  = TW'(TURN_CYC - 1);
      end
      ST_TURN: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  AST_READ_THEN_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RACC && state_d != ST_RACC) |=> (state_q == ST_TURN)); // R8
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 2,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 2,
  parameter int TURN_CYC  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int MAXC = max5(SETUP_CYC, WE_CYC, HOLD_CYC, RD_CYC, TURN_CYC);
  localparam int TW   = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam int LW   = DW / 2;

  asram_state_e  state;
  logic          accept, tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q, lane_mask;
  logic [1:0]    be_q;
  logic          rvalid_q, active, writing;

  assign accept = req_valid && req_ready;

  asram_seq #(
    .SETUP_CYC(SETUP_CYC), .WE_CYC(WE_CYC), .HOLD_CYC(HOLD_CYC),
    .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC), .TW(TW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .acc_write(req_write),
    .tmr_done(tmr_done), .state(state), .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  asram_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  assign lane_mask = {{LW{be_q[1]}}, {LW{be_q[0]}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      if (state == ST_RACC && tmr_done) begin
        rdata_q  <= mem_dq_in & lane_mask;
        rvalid_q <= 1'b1;
      end
    end
  end

  assign writing = (state == ST_WSETUP) || (state == ST_WPULSE) || (state == ST_WHOLD);
  assign active  = writing || (state == ST_RACC);

  assign req_ready  = (state == ST_IDLE);
  assign mem_addr   = addr_q;
  assign mem_ce_n   = !active;
  assign mem_we_n   = (state != ST_WPULSE);
  assign mem_oe_n   = (state != ST_RACC);
  assign mem_lb_n   = !(active && be_q[0]);
  assign mem_ub_n   = !(active && be_q[1]);
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = writing;
  assign rsp_valid  = rvalid_q;
  assign rsp_rdata  = rdata_q;

  AST_NO_BUS_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R9
  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_dq_oe)); // R3
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n); // R5
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |=> (mem_ce_n || $stable(mem_addr))); // R10
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && !req_ready) |=> (!mem_dq_oe || $stable(mem_dq_out))); // R4
endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;
  localparam int S = 1, W = 2, H = 1, R = 2, T = 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_out, mem_dq_in;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;

  always #10 clk = ~clk;

  asram_ctrl #(.SETUP_CYC(S), .WE_CYC(W), .HOLD_CYC(H), .RD_CYC(R), .TURN_CYC(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // RAM stand-in: 256 words, indexed by the low address byte
  logic [15:0] ram [256];
  logic [15:0] ref_mem [256];
  initial for (int i = 0; i < 256; i++) begin
    ram[i]     = 16'(i * 16'h0101) ^ 16'h3C5A;
    ref_mem[i] = 16'(i * 16'h0101) ^ 16'h3C5A;
  end

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ?
    { (mem_ub_n ? 8'hEE : ram[mem_addr[7:0]][15:8]),
      (mem_lb_n ? 8'hEE : ram[mem_addr[7:0]][7:0]) } : 16'hDEAD;

  always @(posedge mem_we_n) if (rst_n && !mem_ce_n) begin
    if (!mem_lb_n) ram[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
    if (!mem_ub_n) ram[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit          m_busy = 0, m_wr = 0;
  int          m_t = 0;
  logic [15:0] m_addr = '0, m_data = '0;
  logic [1:0]  m_be = '0;

  always @(posedge clk) if (rst_n) begin
    if (m_busy) begin
      m_t++;
      if (m_t == (m_wr ? S + W + H : R + T)) m_busy = 0;
    end else if (req_valid) begin
      m_busy = 1; m_t = 0; m_wr = req_write;
      m_addr = req_addr; m_data = req_wdata; m_be = req_be;
      if (req_write) begin
        if (req_be[0]) ref_mem[req_addr[7:0]][7:0]  = req_wdata[7:0];
        if (req_be[1]) ref_mem[req_addr[7:0]][15:8] = req_wdata[15:8];
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    bit e_ce, e_we, e_oe, e_oen, e_rv;
    logic [15:0] e_rd;
    e_ce = 0; e_we = 0; e_oe = 0; e_oen = 0; e_rv = 0; e_rd = '0;
    if (m_busy && m_wr) begin
      e_ce = 1; e_oen = 1;
      e_we = (m_t >= S) && (m_t < S + W);
    end else if (m_busy && m_t < R) begin
      e_ce = 1; e_oe = 1;
    end
    if (m_busy && !m_wr && m_t == R) begin
      e_rv = 1;
      e_rd = ref_mem[m_addr[7:0]] & {{8{m_be[1]}}, {8{m_be[0]}}};
    end
    chk(req_ready == !m_busy, "R2", "req_ready", 16'(req_ready), 16'(!m_busy));
    chk(mem_ce_n == !e_ce, e_ce ? "R3/R5" : "R1/R8", "ce_n", 16'(mem_ce_n), 16'(!e_ce));
    chk(mem_we_n == !e_we, "R3", "we_n", 16'(mem_we_n), 16'(!e_we));
    chk(mem_oe_n == !e_oe, "R5", "oe_n", 16'(mem_oe_n), 16'(!e_oe));
    chk(mem_dq_oe == e_oen, "R4", "dq_oe", 16'(mem_dq_oe), 16'(e_oen));
    chk(!(mem_dq_oe && !mem_oe_n), "R9", "clash", 16'(mem_dq_oe), 16'(0));
    chk(mem_lb_n == !(e_ce && m_be[0]), "R7", "lb_n", 16'(mem_lb_n), 16'(!(e_ce && m_be[0])));
    chk(mem_ub_n == !(e_ce && m_be[1]), "R7", "ub_n", 16'(mem_ub_n), 16'(!(e_ce && m_be[1])));
    if (e_ce) chk(mem_addr == m_addr, "R10", "mem_addr", mem_addr, m_addr);
    if (e_oen) chk(mem_dq_out == m_data, "R4", "dq_out", mem_dq_out, m_data);
    chk(rsp_valid == e_rv, "R6", "rsp_valid", 16'(rsp_valid), 16'(e_rv));
    if (e_rv) chk(rsp_rdata == e_rd, "R6/R7", "rsp_rdata", rsp_rdata, e_rd);
  end

  task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] be, input bit keep);
    bit r;
    @(negedge clk); #1;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    forever begin
      r = req_ready;
      @(negedge clk); #1;
      if (r) break;
    end
    if (keep) begin
      req_addr = a ^ 16'h00FF; req_wdata = ~d; req_be = ~be;  // R10: ignored while busy
    end else req_valid = 0;
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  int cyc = 0;
  bit done = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe && req_ready,
        "R1", "idle pins", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready},
        16'b1111101);
    rst_n = 1;
    idle_wait(2);
    issue(1, 16'h0010, 16'hA1B2, 2'b11, 0);   // R3 full write
    idle_wait(4);
    issue(0, 16'h0010, 16'h0000, 2'b11, 0);   // R5 R6 full read
    idle_wait(4);
    issue(1, 16'h0020, 16'h5566, 2'b01, 0);   // R7 low lane write
    issue(1, 16'h0021, 16'h7788, 2'b10, 0);   // R7 high lane write
    issue(1, 16'h0022, 16'hFFFF, 2'b00, 0);   // R7 mask 00
    issue(0, 16'h0020, 16'h0000, 2'b11, 0);
    issue(0, 16'h0021, 16'h0000, 2'b10, 0);   // R7 upper only
    issue(0, 16'h0022, 16'h0000, 2'b01, 0);   // R7 lower only
    issue(0, 16'h0022, 16'h0000, 2'b11, 0);
    // R8 read followed at once by a waiting write, fields changing while busy
    issue(0, 16'h0030, 16'h0000, 2'b11, 1);
    req_write = 1; req_addr = 16'h0031; req_wdata = 16'hC0DE; req_be = 2'b11;
    issue(1, 16'h0031, 16'hC0DE, 2'b11, 0);
    issue(0, 16'h0031, 16'h0000, 2'b11, 0);
    // R10 write with held valid and changing fields
    issue(1, 16'h0040, 16'h1234, 2'b11, 1);
    issue(0, 16'h0040, 16'h0000, 2'b11, 0);
    issue(0, 16'h00BF, 16'h0000, 2'b11, 0);
    for (int i = 0; i < 8; i++) issue(i[0], 16'(16'h0080 + i), 16'(i * 16'h1111), 2'(i), 0);
    for (int i = 0; i < 8; i++) issue(0, 16'(16'h0080 + i), 16'h0, 2'b11, 0);
    idle_wait(6);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule